// File: doc/BRIEF.md
# Auto-Increment Buffer Pointer Port

This block gives a host byte-wide access into a packet buffer made of equal pages. A 16-bit pointer register holds the page source, an auto-step mode and a byte offset inside the page. The host reaches the buffer through a four-byte data window. For each access to the window the block forms the buffer address, drives the write strobe and write data toward the buffer RAM, and returns the read byte one cycle later.

Two inputs give the page number. One is the page at the head of the receive queue. The other is the page held in the host packet-number register. Pointer bit 15 chooses between them.

With auto-step off, the window byte lane (the low two bits of the window offset) is added to the pointer offset, and the pointer does not change. With auto-step on, every window access uses the pointer offset as it stands. The offset then advances by one and wraps within the page.

Top module: `buf_ptr_port`

## Requirements
- R1: After reset the pointer is 0x0000, rdata_o is 0x00 and mem_we_o is low.
- R2: The pointer is loaded by byte writes to offset 6 (bits 7:0) and offset 7 (bits 15:8). A read of offset 6 returns bits 7:0. A read of offset 7 returns bits 15:8 AND 0xF7, so pointer bit 11 always reads as 0.
- R3: For a window access (offsets 8 to 11), mem_addr_o bits 12:11 carry the page. The page is rx_head_page_i when pointer bit 15 is 1 and pkt_num_i when it is 0.
- R4: With pointer bit 14 clear, a window access at offset 8+k uses byte address pointer[10:0]+k, and the pointer is left unchanged.
- R5: With pointer bit 14 set, a window access of either kind (read or write) uses byte address pointer[10:0] whatever the window lane, and then adds one to pointer[10:0].
- R6: The auto-step increment wraps from 2047 to 0 and leaves pointer bits 15:11 unchanged.
- R7: The non-stepping address sum wraps within the page; for example, offset 0x7FE with lane 3 gives byte address 0x001.
- R8: mem_we_o is high only during a valid write to a window offset. In that cycle mem_wdata_o equals acc_wdata_i.
- R9: Read data is registered. The byte read by an access appears on rdata_o on the clock edge that ends the access, and it holds until the next read.
- R10: Writes to offsets other than 6 to 11 leave the pointer unchanged and assert no strobe. Reads of such offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Host byte access this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_reg_i | input | 4 | Register offset of the access |
| acc_wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Registered host read byte |
| rx_head_page_i | input | 2 | Page at the head of the receive queue |
| pkt_num_i | input | 2 | Page in the host packet-number register |
| mem_addr_o | output | 13 | Buffer address {page, byte offset} |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_wdata_o | output | 8 | Buffer write byte |
| mem_rdata_i | input | 8 | Buffer read byte (combinational from mem_addr_o) |

## Verification
The bench builds the block with its default parameters: 2048-byte pages and four pages. With these values the 11-bit offset fills bits 10:0, and bit 11 is the bit that the high-byte read masks. The bench can then reach both wrap points: the auto-step rollover from 0x7FF and the lane-add overflow past the page end. It can also show that bits 15:11 survive a rollover. Both page sources are driven with different values, so a wrong page choice appears directly in the address.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  localparam int PTR_W        = 16;
  localparam int SRC_BIT      = 15;
  localparam int STEP_BIT     = 14;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;

  localparam logic [3:0] OFS_PTR_LO = 4'h6;
  localparam logic [3:0] OFS_PTR_HI = 4'h7;

  function automatic logic is_window(input logic [3:0] ofs);
    return ofs[3:2] == 2'b10;
  endfunction

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_PTR_LO = 2'd1,
    RD_PTR_HI = 2'd2,
    RD_MEM    = 2'd3
  } rd_src_e;
endpackage

// File: rtl/bpp_pointer.sv
module bpp_pointer
  import bpp_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wdata_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [OFS_W-1:0] ofs_next;

  assign ofs_next = ptr_q[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};

  always_comb begin
    ptr_d = ptr_q;
    if (wr_lo_i) begin
      ptr_d[7:0] = wdata_i;
    end else if (wr_hi_i) begin
      ptr_d[15:8] = wdata_i;
    end else if (step_i) begin
      // upper bits keep their value, offset wraps inside the page
      ptr_d[OFS_W-1:0] = ofs_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/bpp_addr_gen.sv
module bpp_addr_gen #(
  parameter int OFS_W  = 11,
  parameter int PAGE_W = 2
) (
  input  logic [OFS_W-1:0]        ofs_i,
  input  logic                    src_rx_i,
  input  logic                    step_i,
  input  logic [1:0]              lane_i,
  input  logic [PAGE_W-1:0]       rx_head_page_i,
  input  logic [PAGE_W-1:0]       pkt_num_i,
  output logic [PAGE_W+OFS_W-1:0] addr_o
);
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  lane_ext;
  logic [OFS_W-1:0]  byte_ofs;

  assign page     = src_rx_i ? rx_head_page_i : pkt_num_i;
  assign lane_ext = {{(OFS_W-2){1'b0}}, lane_i};
  // sum truncated to OFS_W: overflow wraps within the page
  assign byte_ofs = step_i ? ofs_i : ofs_i + lane_ext;
  assign addr_o   = {page, byte_ofs};
endmodule

// File: rtl/bpp_rd_path.sv
module bpp_rd_path
  import bpp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  rd_src_e    src_i,
  input  logic [7:0] ptr_lo_i,
  input  logic [7:0] ptr_hi_i,
  input  logic [7:0] mem_rdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] rd_d, rd_q;

  always_comb begin
    unique case (src_i)
      RD_PTR_LO: rd_d = ptr_lo_i;
      RD_PTR_HI: rd_d = ptr_hi_i & HI_RD_MASK;
      RD_MEM:    rd_d = mem_rdata_i;
      default:   rd_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= 8'h00;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/buf_ptr_port.sv
module buf_ptr_port
  import bpp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int NUM_PAGES  = 4,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [3:0]        acc_reg_i,
  input  logic [7:0]        acc_wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [PAGE_W-1:0] rx_head_page_i,
  input  logic [PAGE_W-1:0] pkt_num_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic [PTR_W-1:0] ptr_q;
  logic             win_acc, wr_lo, wr_hi, step, rd_en;
  rd_src_e          rd_src;

  assign win_acc = acc_valid_i && is_window(acc_reg_i);
  assign wr_lo   = acc_valid_i && acc_write_i && (acc_reg_i == OFS_PTR_LO);
  assign wr_hi   = acc_valid_i && acc_write_i && (acc_reg_i == OFS_PTR_HI);
  assign step    = win_acc && ptr_q[STEP_BIT];
  assign rd_en   = acc_valid_i && !acc_write_i;

  always_comb begin
    if (is_window(acc_reg_i))          rd_src = RD_MEM;
    else if (acc_reg_i == OFS_PTR_LO)  rd_src = RD_PTR_LO;
    else if (acc_reg_i == OFS_PTR_HI)  rd_src = RD_PTR_HI;
    else                               rd_src = RD_ZERO;
  end

  bpp_pointer #(.OFS_W(OFS_W)) i_pointer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (acc_wdata_i),
    .step_i  (step),
    .ptr_o   (ptr_q)
  );

  bpp_addr_gen #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) i_addr_gen (
    .ofs_i          (ptr_q[OFS_W-1:0]),
    .src_rx_i       (ptr_q[SRC_BIT]),
    .step_i         (ptr_q[STEP_BIT]),
    .lane_i         (acc_reg_i[1:0]),
    .rx_head_page_i (rx_head_page_i),
    .pkt_num_i      (pkt_num_i),
    .addr_o         (mem_addr_o)
  );

  bpp_rd_path i_rd_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en),
    .src_i       (rd_src),
    .ptr_lo_i    (ptr_q[7:0]),
    .ptr_hi_i    (ptr_q[15:8]),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign mem_we_o    = win_acc && acc_write_i;
  assign mem_wdata_o = acc_wdata_i;
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
  parameter int OFS_W  = 11,
  parameter int PAGE_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    acc_valid_i,
  input logic                    acc_write_i,
  input logic [3:0]              acc_reg_i,
  input logic [7:0]              rdata_o,
  input logic [PAGE_W-1:0]       rx_head_page_i,
  input logic [PAGE_W-1:0]       pkt_num_i,
  input logic [PAGE_W+OFS_W-1:0] mem_addr_o,
  input logic                    mem_we_o,
  input logic [7:0]              mem_rdata_i,
  input logic [15:0]             ptr_q
);
  logic win;
  assign win = acc_valid_i && (acc_reg_i[3:2] == 2'b10);

  AST_WE_ONLY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (win && acc_write_i)); // R8

  AST_PAGE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win |-> mem_addr_o[PAGE_W+OFS_W-1:OFS_W] == (ptr_q[15] ? rx_head_page_i : pkt_num_i)); // R3

  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && ptr_q[14]) |=> ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + 1'b1); // R5

  AST_STEP_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win |=> ptr_q[15:OFS_W] == $past(ptr_q[15:OFS_W])); // R6

  AST_NOSTEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && !ptr_q[14]) |=> $stable(ptr_q)); // R4

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && !acc_write_i) |=> rdata_o == $past(mem_rdata_i)); // R9

  AST_HI_BIT11_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && acc_reg_i == 4'h7) |=> !rdata_o[3]); // R2
endmodule

bind buf_ptr_port bpp_checker #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) i_bpp_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_write_i    (acc_write_i),
  .acc_reg_i      (acc_reg_i),
  .rdata_o        (rdata_o),
  .rx_head_page_i (rx_head_page_i),
  .pkt_num_i      (pkt_num_i),
  .mem_addr_o     (mem_addr_o),
  .mem_we_o       (mem_we_o),
  .mem_rdata_i    (mem_rdata_i),
  .ptr_q          (ptr_q)
);

// File: tb/test_buf_ptr_port.sv
module test_buf_ptr_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_reg = 4'h0;
  logic [7:0]  acc_wdata = 8'h00;
  logic [7:0]  rdata;
  logic [1:0]  rx_head = 2'd1;
  logic [1:0]  pkt_num = 2'd2;
  logic [12:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  logic [7:0]  ram [int];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buf_ptr_port i_buf_ptr_port (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_reg_i(acc_reg),
    .acc_wdata_i(acc_wdata), .rdata_o(rdata),
    .rx_head_page_i(rx_head), .pkt_num_i(pkt_num),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // {wr, reg, wdata, chk_addr, addr, chk_rd, rd}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 4'h6, 8'h10, 1'b0, 13'h0000, 1'b0, 8'h00},
    {1'b1, 4'h7, 8'h00, 1'b0, 13'h0000, 1'b0, 8'h00},
    {1'b1, 4'h8, 8'hA1, 1'b1, 13'h1010, 1'b0, 8'h00},
    {1'b1, 4'h9, 8'hA2, 1'b1, 13'h1011, 1'b0, 8'h00},
    {1'b1, 4'hB, 8'hA4, 1'b1, 13'h1013, 1'b0, 8'h00},
    {1'b0, 4'h8, 8'h00, 1'b1, 13'h1010, 1'b1, 8'hA1},
    {1'b0, 4'hB, 8'h00, 1'b1, 13'h1013, 1'b1, 8'hA4},
    {1'b0, 4'h6, 8'h00, 1'b0, 13'h0000, 1'b1, 8'h10},
    {1'b1, 4'h7, 8'h40, 1'b0, 13'h0000, 1'b0, 8'h00},
    {1'b1, 4'hB, 8'hB0, 1'b1, 13'h1010, 1'b0, 8'h00},
    {1'b1, 4'h8, 8'hB1, 1'b1, 13'h1011, 1'b0, 8'h00},
    {1'b0, 4'h6, 8'h00, 1'b0, 13'h0000, 1'b1, 8'h12},
    {1'b1, 4'h6, 8'h10, 1'b0, 13'h0000, 1'b0, 8'h00},
    {1'b0, 4'h9, 8'h00, 1'b1, 13'h1010, 1'b1, 8'hB0},
    {1'b0, 4'h8, 8'h00, 1'b1, 13'h1011, 1'b1, 8'hB1},
    {1'b1, 4'h7, 8'h80, 1'b0, 13'h0000, 1'b0, 8'h00},
    {1'b1, 4'h8, 8'hC3, 1'b1, 13'h0812, 1'b0, 8'h00},
    {1'b0, 4'h8, 8'h00, 1'b1, 13'h0812, 1'b1, 8'hC3},
    {1'b0, 4'h7, 8'h00, 1'b0, 13'h0000, 1'b1, 8'h80}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One access; entered just after a negedge, leaves just after the next one.
  task automatic op(input bit wr, input logic [3:0] r, input logic [7:0] wd,
                    input bit ca, input logic [12:0] ea, input string req_a,
                    input bit cr, input logic [7:0] er, input string req_r);
    acc_valid = 1'b1; acc_write = wr; acc_reg = r; acc_wdata = wd;
    #1;
    mem_rdata = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    if (ca) check(req_a, 16'(mem_addr), 16'(ea));
    if (wr && mem_we) ram[int'(mem_addr)] = mem_wdata;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    if (cr) check(req_r, 16'(rdata), 16'(er));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", 16'(rdata), 16'h0);
    check("R1 we", 16'(mem_we), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 4'h6, 8'h00, 0, 0, "", 1, 8'h00, "R1 ptr lo");
    op(0, 4'h7, 8'h00, 0, 0, "", 1, 8'h00, "R1 ptr hi");

    // table: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      op(VEC[i][35], VEC[i][34:31], VEC[i][30:23], VEC[i][22], VEC[i][21:9],
         "R3/R4/R5 addr", VEC[i][8], VEC[i][7:0], "R2/R4/R5/R9 rdata");
    end

    // R3: page follows live rx head input
    rx_head = 2'd3;
    op(0, 4'h8, 8'h00, 1, 13'h1812, "R3 rx page", 0, 8'h00, "");

    // R6: rollover 0x7FF -> 0x000, bits 15:11 kept (bit 11 set, masked on read)
    op(1, 4'h7, 8'h4F, 0, 0, "", 0, 8'h00, "");
    op(1, 4'h6, 8'hFF, 0, 0, "", 0, 8'h00, "");
    op(0, 4'h7, 8'h00, 0, 0, "", 1, 8'h47, "R2 hi mask");
    op(1, 4'hA, 8'h5A, 1, 13'h17FF, "R6 addr before wrap", 0, 8'h00, "");
    op(0, 4'h6, 8'h00, 0, 0, "", 1, 8'h00, "R6 lo wrapped");
    op(0, 4'h7, 8'h00, 0, 0, "", 1, 8'h40, "R6 upper kept");
    op(0, 4'h9, 8'h00, 1, 13'h1000, "R6 addr after wrap", 0, 8'h00, "");

    // R7: non-stepping sum wraps in page
    op(1, 4'h7, 8'h07, 0, 0, "", 0, 8'h00, "");
    op(1, 4'h6, 8'hFE, 0, 0, "", 0, 8'h00, "");
    op(1, 4'hB, 8'h77, 1, 13'h1001, "R7 lane3 wrap", 0, 8'h00, "");
    op(0, 4'hA, 8'h00, 1, 13'h1000, "R7 lane2 wrap", 0, 8'h00, "");
    op(0, 4'hB, 8'h00, 1, 13'h1001, "R7 readback addr", 1, 8'h77, "R7 readback");

    // R10: other offsets ignored, read as zero
    acc_valid = 1'b1; acc_write = 1'b1; acc_reg = 4'h0; acc_wdata = 8'hFF;
    #1 check("R10 no strobe", 16'(mem_we), 16'h0);
    @(negedge clk);
    acc_valid = 1'b0;
    op(0, 4'h6, 8'h00, 0, 0, "", 1, 8'hFE, "R10 ptr lo kept");
    op(0, 4'h7, 8'h00, 0, 0, "", 1, 8'h07, "R10 ptr hi kept");
    op(0, 4'h0, 8'h00, 0, 0, "", 1, 8'h00, "R10 reads zero");

    // R8: strobe only for window write, data passes through
    acc_valid = 1'b1; acc_write = 1'b1; acc_reg = 4'h9; acc_wdata = 8'h3C;
    #1;
    check("R8 we", 16'(mem_we), 16'h1);
    check("R8 wdata", 16'(mem_wdata), 16'h3C);
    @(negedge clk);
    acc_valid = 1'b0;
    #1 check("R8 idle we", 16'(mem_we), 16'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule